// File: doc/BRIEF.md
# Three-Bank Event Interrupt Aggregator

This block gathers one-cycle event strobes from many on-chip sources and holds each one as a sticky pending bit. The pending bits sit in three banks of 32. Every interrupt output has its own mask word for each bank. An output is a level signal that stays high while any bank has a pending bit whose mask bit for that output is also set.

Each source names its event with a packed 7-bit number. The top two bits choose the bank and the low five bits choose the bit inside it. A source can withdraw its own event later with a clear strobe that uses the same numbering. Software works through a simple register port. It reads pending and mask words, clears pending bits by writing ones and programs the masks. The bit for event 32 (bank 1, bit 0) is owned by its source: software writes cannot clear it.

The event and clear strobes are fire-and-forget. Each is accepted in the cycle it is valid and never applies back-pressure, so sources need no ready signal. The register port is a plain write strobe with a combinational read, and it also never stalls.

Top module: `evt_irq_agg`

## Requirements
- R1: An event number selects its bank with bits 6:5 and the bit inside that bank with bits 4:0. For example, event 7'h27 is bank 1, bit 7.
- R2: A set strobe (`evt_set_vld`) sets the addressed pending bit at the next clock edge. The pending bit stays set until it is cleared.
- R3: `irq_req[0]` uses mask group A, `irq_req[1]` uses group B and `irq_req[2]` uses group C. These map to priority levels 13, 11 and 9. An output rises right after the edge that makes (pending AND its mask) non-zero in any bank.
- R4: A register write to a pending word clears every bit written as 1. Bits written as 0 are left unchanged.
- R5: The bit for event 32 (bank 1, bit 0) is not affected by register writes to the pending word.
- R6: A clear strobe (`evt_clr_vld`) clears the addressed pending bit at the next clock edge. This includes the bit for event 32.
- R7: An output stays high while pending AND its mask is non-zero in any of the three banks. It drops only when that AND is zero in every bank.
- R8: Register read map: `reg_addr[3:2]` is the group (0 pending, 1 mask A, 2 mask B, 3 mask C) and `reg_addr[1:0]` is the bank. Every pending and mask word reads back its current value. Bank index 3 reads zero. A write to a mask word replaces it.
- R9: Set and clear strobes whose bank field is 3 change nothing.
- R10: If a set of a bit happens in the same cycle as a software or hardware clear of that same bit, the bit ends up set.
- R11: Reset clears all pending and mask words, so every output is low.
- R12: A mask write changes the outputs right after the edge that stores it, even when the matching bit was already pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set_vld | input | 1 | Event raise strobe |
| evt_set_num | input | 7 | Number of the event being raised |
| evt_clr_vld | input | 1 | Event withdraw strobe from a source |
| evt_clr_num | input | 7 | Number of the event being withdrawn |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (group, bank) |
| reg_wdata | input | 32 | Write data: ones to clear for pending words, the new value for mask words |
| reg_rdata | output | 32 | Combinational read data at `reg_addr` |
| irq_req | output | 3 | Interrupt request levels: A, B, C |

## Verification
The bench checks the protected bit. A design that let software writes reach it would lose an event its source still owns. It also collides a set with a software clear and with a hardware clear of the same bit; a design with the wrong priority would silently drop a freshly raised event. Strobes with bank field 3 are checked as well, because a design that wrapped or aliased them would set bits in bank 0 or bank 1. Random traffic, with pending bits spread over several banks, checks that an output stays high until every bank is clean and that a mask written over an already-pending bit takes effect right after the edge that stores it.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int EVT_BANK_FIELD_W = 2;
  localparam int EVT_NUM_OUTS     = 3;

  typedef enum logic [1:0] {
    GRP_PEND   = 2'd0,
    GRP_MASK_A = 2'd1,
    GRP_MASK_B = 2'd2,
    GRP_MASK_C = 2'd3
  } reg_grp_e;
endpackage

// File: rtl/evt_decode.sv
module evt_decode #(
  parameter int BITS  = 32,
  parameter int BANKS = 3,
  localparam int SEL_W = $clog2(BITS),
  localparam int NUM_W = SEL_W + evt_irq_pkg::EVT_BANK_FIELD_W
) (
  input  logic                        vld,
  input  logic [NUM_W-1:0]            num,
  output logic [BANKS-1:0][BITS-1:0]  hot
);
  localparam int BF_W = evt_irq_pkg::EVT_BANK_FIELD_W;

  logic [BF_W-1:0]  bank_f;
  logic [SEL_W-1:0] bit_f;

  assign bank_f = num[NUM_W-1:SEL_W];
  assign bit_f  = num[SEL_W-1:0];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign hot[b] = (vld && bank_f == BF_W'(b)) ? (BITS'(1) << bit_f) : '0;
  end
endmodule

// File: rtl/evt_pend_bank.sv
module evt_pend_bank #(
  parameter int              BITS = 32,
  parameter logic [BITS-1:0] LOCK = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BITS-1:0] set_hot,
  input  logic [BITS-1:0] hw_clr_hot,
  input  logic            sw_clr_en,
  input  logic [BITS-1:0] sw_clr_bits,
  output logic [BITS-1:0] pend
);
  logic [BITS-1:0] sw_kill;
  logic [BITS-1:0] pend_nxt;

  always_comb begin
    sw_kill  = sw_clr_en ? (sw_clr_bits & ~LOCK) : '0;
    pend_nxt = (pend & ~hw_clr_hot & ~sw_kill) | set_hot;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_nxt;
  end
endmodule

// File: rtl/evt_irq_reduce.sv
module evt_irq_reduce #(
  parameter int BITS  = 32,
  parameter int BANKS = 3
) (
  input  logic [BANKS-1:0][BITS-1:0] pend,
  input  logic [BANKS-1:0][BITS-1:0] mask,
  output logic                       req
);
  always_comb begin
    req = 1'b0;
    for (int b = 0; b < BANKS; b++) req = req | (|(pend[b] & mask[b]));
  end
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg #(
  parameter int BITS      = 32,
  parameter int BANKS     = 3,
  parameter int PROT_BANK = 1,
  parameter int PROT_BIT  = 0,
  localparam int SEL_W  = $clog2(BITS),
  localparam int NUM_W  = SEL_W + evt_irq_pkg::EVT_BANK_FIELD_W,
  localparam int OUTS   = evt_irq_pkg::EVT_NUM_OUTS,
  localparam int BK_W   = evt_irq_pkg::EVT_BANK_FIELD_W,
  localparam int ADDR_W = 2 + BK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_set_vld,
  input  logic [NUM_W-1:0]  evt_set_num,
  input  logic              evt_clr_vld,
  input  logic [NUM_W-1:0]  evt_clr_num,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BITS-1:0]   reg_wdata,
  output logic [BITS-1:0]   reg_rdata,
  output logic [OUTS-1:0]   irq_req
);
  import evt_irq_pkg::*;

  logic [BANKS-1:0][BITS-1:0]            set_hot;
  logic [BANKS-1:0][BITS-1:0]            clr_hot;
  logic [BANKS-1:0][BITS-1:0]            pend_q;
  logic [OUTS-1:0][BANKS-1:0][BITS-1:0]  mask_q;

  reg_grp_e        grp;
  logic [BK_W-1:0] bk;

  assign grp = reg_grp_e'(reg_addr[ADDR_W-1:BK_W]);
  assign bk  = reg_addr[BK_W-1:0];

  evt_decode #(.BITS(BITS), .BANKS(BANKS)) u_set_dec (
    .vld(evt_set_vld), .num(evt_set_num), .hot(set_hot)
  );

  evt_decode #(.BITS(BITS), .BANKS(BANKS)) u_clr_dec (
    .vld(evt_clr_vld), .num(evt_clr_num), .hot(clr_hot)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_pend
    localparam logic [BITS-1:0] LOCK_B = (b == PROT_BANK) ? (BITS'(1) << PROT_BIT) : '0;
    logic wr_this;
    assign wr_this = reg_wr && grp == GRP_PEND && bk == BK_W'(b);

    evt_pend_bank #(.BITS(BITS), .LOCK(LOCK_B)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_hot    (set_hot[b]),
      .hw_clr_hot (clr_hot[b]),
      .sw_clr_en  (wr_this),
      .sw_clr_bits(reg_wdata),
      .pend       (pend_q[b])
    );
  end

  for (genvar o = 0; o < OUTS; o++) begin : g_out
    for (genvar b = 0; b < BANKS; b++) begin : g_mbank
      always_ff @(posedge clk) begin
        if (!rst_n)
          mask_q[o][b] <= '0;
        else if (reg_wr && reg_addr[ADDR_W-1:BK_W] == 2'(o + 1) && bk == BK_W'(b))
          mask_q[o][b] <= reg_wdata;
      end
    end

    evt_irq_reduce #(.BITS(BITS), .BANKS(BANKS)) u_reduce (
      .pend(pend_q), .mask(mask_q[o]), .req(irq_req[o])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (bk == BK_W'(b)) begin
        case (grp)
          GRP_PEND:   reg_rdata = pend_q[b];
          GRP_MASK_A: reg_rdata = mask_q[0][b];
          GRP_MASK_B: reg_rdata = mask_q[1][b];
          GRP_MASK_C: reg_rdata = mask_q[2][b];
          default:    reg_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/evt_irq_agg_chk.sv
module evt_irq_agg_chk #(
  parameter int BITS      = 32,
  parameter int BANKS     = 3,
  parameter int PROT_BANK = 1,
  parameter int PROT_BIT  = 0,
  localparam int SEL_W = $clog2(BITS),
  localparam int NUM_W = SEL_W + 2,
  localparam int FLAT  = 1 << NUM_W,
  localparam int PROT_NUM = PROT_BANK * BITS + PROT_BIT
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       evt_set_vld,
  input logic [NUM_W-1:0]           evt_set_num,
  input logic                       evt_clr_vld,
  input logic [NUM_W-1:0]           evt_clr_num,
  input logic                       reg_wr,
  input logic [BANKS-1:0][BITS-1:0] pend,
  input logic [2:0]                 irq_req
);
  logic [FLAT-1:0] flat;
  logic            set_ok;
  logic            clr_ok;

  always_comb begin
    flat = '0;
    for (int b = 0; b < BANKS; b++) flat[b*BITS +: BITS] = pend[b];
  end

  assign set_ok = evt_set_vld && (int'(evt_set_num[NUM_W-1:SEL_W]) < BANKS);
  assign clr_ok = evt_clr_vld && (int'(evt_clr_num[NUM_W-1:SEL_W]) < BANKS);

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    set_ok |=> flat[$past(evt_set_num)]); // R2

  AST_PROT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flat[PROT_NUM] && !(evt_clr_vld && int'(evt_clr_num) == PROT_NUM)) |=> flat[PROT_NUM]); // R5

  AST_HW_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ok && !(evt_set_vld && evt_set_num == evt_clr_num)) |=> !flat[$past(evt_clr_num)]); // R6

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (flat == '0) |-> (irq_req == 3'b000)); // R7

  AST_BANK3_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set_vld && !set_ok && !evt_clr_vld && !reg_wr) |=> (flat == $past(flat))); // R9
endmodule

bind evt_irq_agg evt_irq_agg_chk #(
  .BITS(BITS), .BANKS(BANKS), .PROT_BANK(PROT_BANK), .PROT_BIT(PROT_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_set_vld(evt_set_vld),
  .evt_set_num(evt_set_num),
  .evt_clr_vld(evt_clr_vld),
  .evt_clr_num(evt_clr_num),
  .reg_wr     (reg_wr),
  .pend       (pend_q),
  .irq_req    (irq_req)
);

// File: tb/test_evt_irq_agg.sv
`timescale 1ns/1ps
module test_evt_irq_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_set_vld = 1'b0;
  logic [6:0]  evt_set_num = '0;
  logic        evt_clr_vld = 1'b0;
  logic [6:0]  evt_clr_num = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  irq_req;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] m_pend [3];
  logic [31:0] m_mask [3][3];

  always #4 clk = ~clk;

  evt_irq_agg i_evt_irq_agg (
    .clk(clk), .rst_n(rst_n),
    .evt_set_vld(evt_set_vld), .evt_set_num(evt_set_num),
    .evt_clr_vld(evt_clr_vld), .evt_clr_num(evt_clr_num),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req)
  );

  function automatic logic [31:0] hot(input logic v, input logic [6:0] n, input int b);
    return (v && int'(n[6:5]) == b) ? (32'd1 << n[4:0]) : 32'd0;
  endfunction

  function automatic logic [2:0] exp_irq();
    logic [2:0] r = '0;
    for (int o = 0; o < 3; o++)
      for (int b = 0; b < 3; b++) r[o] = r[o] | (|(m_pend[b] & m_mask[o][b]));
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    if (a[1:0] == 2'd3) return 32'd0;
    if (a[3:2] == 2'd0) return m_pend[a[1:0]];
    return m_mask[a[3:2]-1][a[1:0]];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at negedge, model the edge, check irq at the following negedge.
  task automatic step(input string req, input logic sv, input logic [6:0] sn,
                      input logic cv, input logic [6:0] cn,
                      input logic wv, input logic [3:0] wa, input logic [31:0] wd);
    logic [31:0] sw;
    evt_set_vld = sv; evt_set_num = sn;
    evt_clr_vld = cv; evt_clr_num = cn;
    reg_wr = wv; reg_addr = wa; reg_wdata = wd;
    @(posedge clk);
    #1;
    for (int b = 0; b < 3; b++) begin
      sw = (wv && wa[3:2] == 2'd0 && int'(wa[1:0]) == b) ? wd : 32'd0;
      if (b == 1) sw[0] = 1'b0;
      m_pend[b] = (m_pend[b] & ~sw & ~hot(cv, cn, b)) | hot(sv, sn, b);
      for (int o = 0; o < 3; o++)
        if (wv && int'(wa[3:2]) == o + 1 && int'(wa[1:0]) == b) m_mask[o][b] = wd;
    end
    @(negedge clk);
    evt_set_vld = 1'b0; evt_clr_vld = 1'b0; reg_wr = 1'b0;
    check(req, {29'd0, irq_req}, {29'd0, exp_irq()});
  endtask

  task automatic readback(input string req);
    reg_wr = 1'b0;
    for (int a = 0; a < 16; a++) begin
      reg_addr = 4'(a);
      #1;
      check(req, reg_rdata, exp_rd(4'(a)));
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1DEA5EED));
    for (int b = 0; b < 3; b++) begin
      m_pend[b] = '0;
      for (int o = 0; o < 3; o++) m_mask[o][b] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state
    check("R11", {29'd0, irq_req}, 32'd0);
    readback("R11");

    // R1/R2/R12: event 7'h27 = bank 1 bit 7, mask written afterwards
    step("R2", 1, 7'h27, 0, 0, 0, 0, 0);
    readback("R1");
    step("R12", 0, 0, 0, 0, 1, 4'b1001, 32'h0000_0080);
    check("R3", {29'd0, irq_req}, 32'd2);
    // R7: a second bank pending, clear one, output stays high
    step("R3", 0, 0, 0, 0, 1, 4'b1000, 32'h0000_0001);
    step("R7", 1, 7'h00, 0, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 0, 1, 4'b0001, 32'h0000_0080);
    check("R7", {29'd0, irq_req}, 32'd2);
    step("R6", 0, 0, 1, 7'h00, 0, 0, 0);
    check("R7", {29'd0, irq_req}, 32'd0);

    // R5: protected event 32
    step("R5", 1, 7'h20, 0, 0, 1, 4'b0101, 32'h0000_0001);
    step("R5", 0, 0, 0, 0, 1, 4'b0001, 32'hFFFF_FFFF);
    check("R5", {29'd0, irq_req}, 32'd1);
    readback("R5");
    step("R6", 0, 0, 1, 7'h20, 0, 0, 0);
    check("R6", {29'd0, irq_req}, 32'd0);

    // R9: bank field 3
    step("R9", 1, 7'h65, 0, 0, 0, 0, 0);
    readback("R9");
    step("R9", 1, 7'h02, 0, 0, 0, 0, 0);
    step("R9", 0, 0, 1, 7'h62, 0, 0, 0);
    readback("R9");

    // R10: set vs software clear, set vs hardware clear
    step("R10", 1, 7'h44, 0, 0, 1, 4'b0010, 32'h0000_0010);
    step("R10", 1, 7'h45, 1, 7'h45, 0, 0, 0);
    readback("R10");

    // R8: mask readback after random mask programming
    for (int i = 0; i < 9; i++)
      step("R8", 0, 0, 0, 0, 1, 4'(((i / 3) + 1) * 4 + (i % 3)), $urandom());
    readback("R8");

    // Random traffic
    for (int i = 0; i < 600; i++) begin
      logic [3:0] wa;
      wa = 4'($urandom_range(0, 15));
      step("R7", ($urandom_range(0, 3) != 0), 7'($urandom()),
           ($urandom_range(0, 2) == 0), 7'($urandom()),
           ($urandom_range(0, 3) == 0), wa,
           ($urandom_range(0, 1) == 0) ? 32'hFFFF_FFFF : $urandom());
      if (i % 50 == 49) readback("R8");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule